// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block carries out the status-word and stack-pointer update that a processor performs when it leaves an exception handler or a non-maskable interrupt handler. The status word keeps a stack of flag contexts in ten-bit slices. A return pops one slice by moving the body of the word ten places toward bit 0. The two top bits stay where they are. The two bits below them are cleared. The pending flag is then forced on, unless the return-enable flag was already set before the pop. A return from the non-maskable handler also forces the NMI-mask flag on.

When the popped context has the user-mode flag set, the block swaps the stack pointers. The live stack pointer is saved as the kernel stack pointer, and the saved user stack pointer becomes the live one. The surrounding core gives a one-cycle command together with the current status, the current stack pointer and the saved user stack pointer. It takes the registered results one clock later.

Top module: `exc_return_unit`

## Requirements
- R1: While `rstN` is low, `statusOut`, `spOut` and `kspOut` are all zero.
- R2: `cmd` is encoded as 0 = idle, 1 = exception return, 2 = NMI return, 3 = reserved. Idle and reserved leave all three outputs unchanged, whatever the data inputs are.
- R3: On a return, the new status has these fields: bits 31:30 equal the old bits 31:30; bits 29:18 are zero; bits 17:0 equal the old bits 27:10. Bits 7 and 9 are the exceptions, because R4 and R5 may force them.
- R4: On either kind of return, status bit 7 (pending) is forced to 1 when the old bit 8 (return-enable) was 0. When the old bit 8 was 1, bit 7 takes the shifted value, which is old bit 17.
- R5: Only an NMI return forces status bit 9 (NMI mask) to 1. An exception return leaves it at the shifted value, which is old bit 19.
- R6: The return-enable test of R4 uses the status before the shift. An old bit 18, which moves into bit 8, has no effect on bit 7.
- R7: The user-mode test uses bit 6 of the status after the shift, which is old bit 16. When it is set, `kspOut` takes the old `spIn` and `spOut` takes `userSpIn`.
- R8: When the shifted bit 6 is clear, `spOut` takes `spIn` and `kspOut` keeps its value. An old bit 6 by itself does not cause a swap.
- R9: All outputs change on the first rising clock edge at which a command is sampled. They then hold until the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Return command (see R2) |
| statusIn | input | 32 | Current status word |
| spIn | input | 32 | Current stack pointer |
| userSpIn | input | 32 | Saved user stack pointer |
| statusOut | output | 32 | Updated status word |
| spOut | output | 32 | Updated stack pointer |
| kspOut | output | 32 | Saved kernel stack pointer |

## Verification
The bench targets each corner case of the flag logic.
- A status with old bit 18 set and old bit 8 clear catches a design that tests return-enable after the shift: such a design would leave the pending flag clear.
- A status with only old bit 6 set catches a design that tests user mode before the shift: it would swap the stack pointers when it should not.
- A design that ignored the reserved command code would corrupt all three outputs.
- A design with the wrong mask for the cleared bits 29:28 would show stale bits in 29:18.
- A design that set the mask flag on an exception return would differ at bit 9.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_RET_EXC = 2'd1,
    CMD_RET_NMI = 2'd2,
    CMD_RSVD    = 2'd3
  } retCmdE;

  typedef struct packed {
    logic load;
    logic forceP;
    logic forceM;
  } retStrobeS;
endpackage

// File: rtl/exc_ret_ctrl.sv
module exc_ret_ctrl
  import exc_ret_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int R_BIT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] statusIn,
  output retStrobeS        strobe
);
  retCmdE cmdE;

  always_comb begin
    cmdE = retCmdE'(cmd);
    strobe = '0;
    if (cmdE == CMD_RET_EXC || cmdE == CMD_RET_NMI) begin
      strobe.load   = 1'b1;
      strobe.forceP = ~statusIn[R_BIT];
      strobe.forceM = (cmdE == CMD_RET_NMI);
    end
  end

  // R5: the mask strobe only accompanies a load
  a_r5_mask_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceM |-> strobe.load);
  // R2: idle and reserved codes raise no strobe
  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 2'd0 || cmd == 2'd3) |-> (strobe == '0));
endmodule

// File: rtl/exc_ret_datapath.sv
module exc_ret_datapath
  import exc_ret_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int SHIFT_AMT  = 10,
  parameter int KEEP_BITS  = 2,
  parameter int CLEAR_BITS = 2,
  parameter int U_BIT      = 6,
  parameter int P_BIT      = 7,
  parameter int R_BIT      = 8,
  parameter int M_BIT      = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  retStrobeS        strobe,
  input  logic [WIDTH-1:0] statusIn,
  input  logic [WIDTH-1:0] spIn,
  input  logic [WIDTH-1:0] userSpIn,
  output logic [WIDTH-1:0] statusOut,
  output logic [WIDTH-1:0] spOut,
  output logic [WIDTH-1:0] kspOut
);
  localparam int BODY_MSB = WIDTH - KEEP_BITS - CLEAR_BITS - 1;
  localparam int LOW_MSB  = BODY_MSB - SHIFT_AMT;

  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] flagMask;
  logic [WIDTH-1:0] newStatus;
  logic             userMode;

  always_comb begin
    shifted = '0;
    shifted[WIDTH-1 -: KEEP_BITS] = statusIn[WIDTH-1 -: KEEP_BITS];
    shifted[LOW_MSB:0] = statusIn[BODY_MSB:SHIFT_AMT];
    flagMask = '0;
    flagMask[P_BIT] = strobe.forceP;
    flagMask[M_BIT] = strobe.forceM;
    newStatus = shifted | flagMask;
    userMode = shifted[U_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusOut <= '0;
      spOut     <= '0;
      kspOut    <= '0;
    end else if (strobe.load) begin
      statusOut <= newStatus;
      if (userMode) begin
        kspOut <= spIn;
        spOut  <= userSpIn;
      end else begin
        spOut  <= spIn;
      end
    end
  end

  // R9: nothing moves without a command
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(statusOut) && $stable(spOut) && $stable(kspOut)));
  // R3: top bits kept, cleared field zero
  a_r3_top_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (statusOut[WIDTH-1 -: KEEP_BITS] == $past(statusIn[WIDTH-1 -: KEEP_BITS])
                     && statusOut[BODY_MSB+CLEAR_BITS -: CLEAR_BITS] == '0));
  // R4 / R6: pending flag follows the pre-shift return-enable flag
  a_r4_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !statusIn[R_BIT]) |=> statusOut[P_BIT]);
  // R5: NMI return sets the mask flag
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceM |=> statusOut[M_BIT]);
  // R7: user-mode swap
  a_r7_swap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && statusIn[U_BIT+SHIFT_AMT]) |=>
      (spOut == $past(userSpIn) && kspOut == $past(spIn)));
  // R8: no swap keeps the kernel copy
  a_r8_no_swap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !statusIn[U_BIT+SHIFT_AMT]) |=>
      (spOut == $past(spIn) && $stable(kspOut)));
endmodule

// File: rtl/exc_return_unit.sv
module exc_return_unit
  import exc_ret_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int SHIFT_AMT  = 10,
  parameter int KEEP_BITS  = 2,
  parameter int CLEAR_BITS = 2,
  parameter int U_BIT      = 6,
  parameter int P_BIT      = 7,
  parameter int R_BIT      = 8,
  parameter int M_BIT      = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] statusIn,
  input  logic [WIDTH-1:0] spIn,
  input  logic [WIDTH-1:0] userSpIn,
  output logic [WIDTH-1:0] statusOut,
  output logic [WIDTH-1:0] spOut,
  output logic [WIDTH-1:0] kspOut
);
  retStrobeS strobe;

  exc_ret_ctrl #(.WIDTH(WIDTH), .R_BIT(R_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .statusIn(statusIn), .strobe(strobe)
  );

  exc_ret_datapath #(
    .WIDTH(WIDTH), .SHIFT_AMT(SHIFT_AMT), .KEEP_BITS(KEEP_BITS),
    .CLEAR_BITS(CLEAR_BITS), .U_BIT(U_BIT), .P_BIT(P_BIT),
    .R_BIT(R_BIT), .M_BIT(M_BIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .spIn(spIn), .userSpIn(userSpIn), .statusOut(statusOut),
    .spOut(spOut), .kspOut(kspOut)
  );
endmodule

// File: tb/test_exc_return_unit.sv
module test_exc_return_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [31:0] statusIn = '0, spIn = '0, userSpIn = '0;
  logic [31:0] statusOut, spOut, kspOut;
  logic [31:0] expStatus = '0, expSp = '0, expKsp = '0;
  int          checks = 0, fails = 0;
  bit          running = 1'b1;
  string       curTag = "R1";

  always #5 clk = ~clk;

  exc_return_unit i_exc_return_unit (
    .clk(clk), .rstN(rstN), .cmd(cmd), .statusIn(statusIn), .spIn(spIn),
    .userSpIn(userSpIn), .statusOut(statusOut), .spOut(spOut), .kspOut(kspOut)
  );

  // behavioural reference, updated at the same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expStatus <= '0; expSp <= '0; expKsp <= '0;
    end else if (cmd == 2'd1 || cmd == 2'd2) begin
      logic [31:0] s;
      s = (statusIn & 32'hC000_0000) | ((statusIn & 32'h0FFF_FFFF) >> 10);
      if (statusIn[8] == 1'b0) s = s | 32'h0000_0080;
      if (cmd == 2'd2)         s = s | 32'h0000_0200;
      expStatus <= s;
      if (s[6]) begin
        expKsp <= spIn;
        expSp  <= userSpIn;
      end else begin
        expSp  <= spIn;
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", curTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cmp("statusOut", statusOut, expStatus);
      cmp("spOut", spOut, expSp);
      cmp("kspOut", kspOut, expKsp);
    end
  end

  task automatic drive(string tag, logic [1:0] c, logic [31:0] st,
                       logic [31:0] sp, logic [31:0] usp);
    @(negedge clk);
    curTag = tag; cmd = c; statusIn = st; spIn = sp; userSpIn = usp;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    running = 1'b0;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    // R1: reset values
    curTag = "R1";
    repeat (3) @(negedge clk);
    drive("R1", 2'd0, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222);
    rstN = 1'b1;
    // seed kernel copy with a user-mode return: R7
    drive("R7", 2'd1, 32'h0001_0000, 32'hA000_0010, 32'hB000_0020);
    // R2: idle and reserved do nothing
    drive("R2", 2'd0, 32'hFFFF_FFFF, 32'h3333_3333, 32'h4444_4444);
    drive("R2", 2'd3, 32'hFFFF_FFFF, 32'h5555_5555, 32'h6666_6666);
    drive("R2", 2'd3, 32'h0000_0000, 32'h7777_7777, 32'h8888_8888);
    // R3: field movement with all bits set, and a mixed pattern
    drive("R3", 2'd1, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_2000);
    drive("R3", 2'd1, 32'h9ABC_DEF0, 32'h0000_1004, 32'h0000_2004);
    // R4: return-enable clear sets pending; set keeps shifted bit
    drive("R4", 2'd1, 32'h0000_0000, 32'h0000_1008, 32'h0000_2008);
    drive("R4", 2'd1, 32'h0000_0100, 32'h0000_100C, 32'h0000_200C);
    drive("R4", 2'd1, 32'h0002_0100, 32'h0000_1010, 32'h0000_2010);
    // R5: NMI return sets mask; exception return does not
    drive("R5", 2'd2, 32'h0000_0100, 32'h0000_1014, 32'h0000_2014);
    drive("R5", 2'd1, 32'h0000_0300, 32'h0000_1018, 32'h0000_2018);
    drive("R5", 2'd2, 32'h4008_0000, 32'h0000_101C, 32'h0000_201C);
    // R6: bit landing in return-enable does not block pending
    drive("R6", 2'd1, 32'h0004_0000, 32'h0000_1020, 32'h0000_2020);
    drive("R6", 2'd2, 32'h0004_0000, 32'h0000_1024, 32'h0000_2024);
    // R7: post-shift user flag swaps
    drive("R7", 2'd2, 32'h0001_0100, 32'hC000_0030, 32'hD000_0040);
    // R8: pre-shift bit 6 alone does not swap
    drive("R8", 2'd1, 32'h0000_0040, 32'hE000_0050, 32'hF000_0060);
    drive("R8", 2'd2, 32'h0000_0140, 32'hE000_0054, 32'hF000_0064);
    // R9: single pulse then hold
    drive("R9", 2'd1, 32'h0123_4567, 32'h0BAD_0001, 32'h0BAD_0002);
    for (int i = 0; i < 4; i++)
      drive("R9", 2'd0, $urandom, $urandom, $urandom);
    // R3: random mix of commands
    for (int i = 0; i < 200; i++)
      drive("R3", 2'($urandom_range(0, 3)), $urandom, $urandom, $urandom);
    // R1: reset again clears outputs
    drive("R1", 2'd0, 32'h0, 32'h0, 32'h0);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    @(posedge clk);
    running = 1'b0;
    summary();
  end
endmodule